// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers sixteen level-sensitive interrupt lines from local-bus peripherals into a single interrupt request toward the processor. Each line is captured every clock into a source register, so a source bit stays set exactly as long as its line is held high. A sixteen-bit enable mask selects which captured sources may count as pending. The combined request `irq_o` is high whenever at least one enabled source is pending.

Software services the request by reading the vector register. The value it returns identifies the pending enabled source with the lowest index, which gives that source the highest priority. The value is that index plus one, shifted left by two, and it is zero when nothing is pending. The register port takes 16-bit accesses only. An access counts as 16-bit when both byte enables are set; any other access has no effect.

The request output comes from a two-state machine. `IRQ_QUIET` means no enabled source is pending and `IRQ_RAISED` means at least one is. The transition RAISE (QUIET to RAISED) is taken when the next-cycle pending set is nonzero. The transition DROP (RAISED to QUIET) is taken when it becomes empty. In every other case the machine holds its state. The next-cycle pending set is formed from the incoming line levels and from the mask value that takes effect at the same edge. The request therefore changes at the same clock edge as the source register or the mask.

Top module: `lbirq_top`

## Requirements
- R1: Source bit i takes the level of `irq_in[i]` at each rising clock edge, so it is set while the line is high and clear while it is low.
- R2: `irq_o` equals the OR of (source register AND mask), and it is registered. A change on `irq_in` that is driven between edges shows on `irq_o` only after the next rising edge.
- R3: A 16-bit read at offset 0x000 returns (i+1)<<2, where i is the lowest-numbered bit set in (source AND mask). It returns 0 when that set is empty (bit 0 gives 4, bit 15 gives 64).
- R4: Offset 0x002 holds the mask, which can be read and written. A 16-bit write there replaces the mask at the next edge, and `irq_o` reflects the new mask from that same edge.
- R5: After reset the mask is 0x0010, the source register is 0 and `irq_o` is low.
- R6: An access whose `bus_be` is not 2'b11 is ignored. A write of this kind leaves the mask unchanged, and a read of this kind returns 0.
- R7: Offsets other than 0x000 and 0x002 read as 0, and writes to them are ignored.
- R8: The vector register at 0x000 is read-only. A write to it changes neither the mask nor `irq_o`.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low.
- R10: A pending source whose mask bit is 0 affects neither `irq_o` nor the vector. Priority is decided among enabled sources only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Level-sensitive interrupt lines, one per source |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acted on at the rising edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_be | input | 2 | Byte enables; 2'b11 marks a valid 16-bit access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when no valid read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen sources, a 12-bit offset, a 16-bit data path, reset mask 0x0010 and a vector shift of two. With these values every priority position from bit 0 (vector 4) to bit 15 (vector 64) can be reached. The reset mask, which enables only source 4, can be seen to filter the other fifteen lines before software rewrites it. Random line levels and random mask writes are mixed with directed cases for the extreme priority positions, partial byte enables, unmapped offsets and writes to the read-only vector.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;

    // State of the combined request output
    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // Byte-enable pattern that marks a full 16-bit access
    localparam logic [1:0] BE_FULL = 2'b11;

endpackage

// File: rtl/lbirq_src_reg.sv
module lbirq_src_reg #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvl_i,
    output logic [N_SRC-1:0] src_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_o <= '0;
        else        src_o <= lvl_i;
    end

    // R1
    src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> src_o == $past(lvl_i));

endmodule

// File: rtl/lbirq_mask_reg.sv
module lbirq_mask_reg #(
    parameter int unsigned      N_SRC    = 16,
    parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit_i,
    input  logic [N_SRC-1:0] wdata_i,
    output logic [N_SRC-1:0] mask_o,
    output logic [N_SRC-1:0] mask_nx_o
);

    always_comb begin
        mask_nx_o = wr_hit_i ? wdata_i : mask_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_o <= MASK_RST;
        else        mask_o <= mask_nx_o;
    end

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit_i)) |-> mask_o == $past(wdata_i));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_hit_i) |-> $stable(mask_o));

endmodule

// File: rtl/lbirq_prio_enc.sv
module lbirq_prio_enc #(
    parameter int unsigned N_SRC  = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  pend_i,
    output logic              any_o,
    output logic [DATA_W-1:0] vec_o
);

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC:0]   seen;
    logic [N_SRC-1:0] first_oh;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] num;

    assign seen[0] = 1'b0;

    // Prefix-OR chain: a bit wins only if no lower bit is pending
    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_chain
            assign seen[g+1]   = seen[g] | pend_i[g];
            assign first_oh[g] = pend_i[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (first_oh[k]) idx = idx | IDX_W'(k);
        end
    end

    always_comb begin
        any_o = seen[N_SRC];
        num   = DATA_W'(idx) + DATA_W'(1);
        vec_o = any_o ? (num << SHIFT) : '0;
    end

    // R3
    first_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_oh));

    // R3
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[idx]);

    // R3
    nothing_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pend_i & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0);

endmodule

// File: rtl/lbirq_out_fsm.sv
module lbirq_out_fsm
    import lbirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // Transitions: RAISE and DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!raise_i) state_d = IRQ_QUIET;
        endcase
    end

    // Output
    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R2
    irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_o == $past(raise_i));

endmodule

// File: rtl/lbirq_top.sv
module lbirq_top
    import lbirq_pkg::*;
#(
    parameter int unsigned      N_SRC    = 16,
    parameter int unsigned      ADDR_W   = 12,
    parameter int unsigned      DATA_W   = 16,
    parameter int unsigned      SHIFT    = 2,
    parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] VEC_OFF  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(2);

    logic              acc_ok;
    logic              mask_wr;
    logic [N_SRC-1:0]  src_q;
    logic [N_SRC-1:0]  mask_q;
    logic [N_SRC-1:0]  mask_nx;
    logic              pend_any;
    logic [DATA_W-1:0] vec;
    logic              raise_nx;

    always_comb begin
        acc_ok  = (bus_be == BE_FULL);
        mask_wr = bus_wr && acc_ok && (bus_addr == MASK_OFF);
    end

    lbirq_src_reg #(.N_SRC(N_SRC)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (irq_in),
        .src_o (src_q)
    );

    lbirq_mask_reg #(.N_SRC(N_SRC), .MASK_RST(MASK_RST)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit_i  (mask_wr),
        .wdata_i   (bus_wdata[N_SRC-1:0]),
        .mask_o    (mask_q),
        .mask_nx_o (mask_nx)
    );

    lbirq_prio_enc #(.N_SRC(N_SRC), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (src_q & mask_q),
        .any_o  (pend_any),
        .vec_o  (vec)
    );

    // Pending set that will hold after the coming edge
    always_comb begin
        raise_nx = |(irq_in & mask_nx);
    end

    lbirq_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise_nx),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && acc_ok) begin
            unique case (bus_addr)
                VEC_OFF:  bus_rdata = vec;
                MASK_OFF: bus_rdata = DATA_W'(mask_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == pend_any);

    // R6
    partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != BE_FULL) |=> $stable(mask_q));

endmodule

// File: tb/tb_lbirq_top.sv
module tb_lbirq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_src;
    logic [15:0] m_mask;

    always #4 clk = ~clk;

    lbirq_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [15:0] exp_vec(input logic [15:0] s, input logic [15:0] m);
        logic [15:0] p = s & m;
        for (int i = 0; i < 16; i++) begin
            if (p[i]) return 16'((i + 1) << 2);
        end
        return 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle of stimulus; the model follows R1, R4, R6, R7, R8
    task automatic step(input logic [15:0] lv, input logic wr, input logic [11:0] a,
                        input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        irq_in = lv; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; bus_rd = 1'b0;
        #1;
        // R2: nothing moves before the edge
        check("R2 pre-edge", {15'd0, irq_o}, {15'd0, |(m_src & m_mask)});
        @(posedge clk);
        m_src = lv;
        if (wr && be == 2'b11 && a == 12'h002) m_mask = d;
        #1;
        bus_wr = 1'b0;
        check("R2 post-edge", {15'd0, irq_o}, {15'd0, |(m_src & m_mask)});
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [1:0] be,
                      input logic [15:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        #1;
        check(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lv, d;
        void'($urandom(32'd1234));
        rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 0; bus_rd = 0;
        bus_be = 2'b11; bus_wdata = '0;
        m_src = '0; m_mask = 16'h0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R5
        check("R5 irq after reset", {15'd0, irq_o}, 16'h0);
        rd("R5 mask reset value", 12'h002, 2'b11, 16'h0010);
        rd("R5 R3 vector empty", 12'h000, 2'b11, 16'h0000);

        // R1 R3: source 4 enabled by reset mask
        step(16'h0010, 0, 12'h0, 16'h0, 2'b11);
        check("R1 irq on source 4", {15'd0, irq_o}, 16'h1);
        rd("R3 vector source 4", 12'h000, 2'b11, 16'h0014);
        // R10: source 3 masked off
        step(16'h0008, 0, 12'h0, 16'h0, 2'b11);
        check("R10 masked source no irq", {15'd0, irq_o}, 16'h0);
        rd("R10 masked vector", 12'h000, 2'b11, 16'h0000);
        // R4: enable all, irq rises at that edge
        step(16'h0008, 1, 12'h002, 16'hFFFF, 2'b11);
        check("R4 irq after mask write", {15'd0, irq_o}, 16'h1);
        rd("R4 mask readback", 12'h002, 2'b11, 16'hFFFF);
        rd("R3 vector source 3", 12'h000, 2'b11, 16'h0010);
        // R3 extremes
        step(16'h8000, 0, 12'h0, 16'h0, 2'b11);
        rd("R3 vector source 15", 12'h000, 2'b11, 16'h0040);
        step(16'h8001, 0, 12'h0, 16'h0, 2'b11);
        rd("R3 vector source 0 wins", 12'h000, 2'b11, 16'h0004);
        // R10: lowest pending masked, next one wins
        step(16'h8001, 1, 12'h002, 16'h8000, 2'b11);
        rd("R10 priority among enabled", 12'h000, 2'b11, 16'h0040);
        // R6: partial byte enables
        step(16'h8001, 1, 12'h002, 16'h0000, 2'b01);
        rd("R6 partial write ignored", 12'h002, 2'b11, 16'h8000);
        check("R6 irq kept", {15'd0, irq_o}, 16'h1);
        rd("R6 partial read zero", 12'h002, 2'b10, 16'h0000);
        // R8: write to vector register
        step(16'h8001, 1, 12'h000, 16'h0000, 2'b11);
        rd("R8 vector write ignored", 12'h002, 2'b11, 16'h8000);
        check("R8 irq kept", {15'd0, irq_o}, 16'h1);
        // R7: unmapped offsets
        step(16'h8001, 1, 12'h004, 16'h0000, 2'b11);
        rd("R7 unmapped write ignored", 12'h002, 2'b11, 16'h8000);
        rd("R7 unmapped read 0x004", 12'h004, 2'b11, 16'h0000);
        rd("R7 unmapped read 0x001", 12'h001, 2'b11, 16'h0000);
        // R9
        @(negedge clk); bus_addr = 12'h002; bus_be = 2'b11; bus_rd = 1'b0; #1;
        check("R9 rdata idle", bus_rdata, 16'h0000);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            lv = 16'($urandom);
            if ($urandom_range(0, 3) == 0) lv = 16'h0;
            d  = 16'($urandom);
            if ($urandom_range(0, 2) == 0)
                step(lv, 1, 12'h002, d, ($urandom_range(0, 4) == 0) ? 2'b01 : 2'b11);
            else
                step(lv, 0, 12'h000, d, 2'b11);
            rd("R3 random vector", 12'h000, 2'b11, exp_vec(m_src, m_mask));
            if (n % 8 == 0) rd("R4 random mask", 12'h002, 2'b11, m_mask);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule